// File: doc/BRIEF.md
# CAN Controller Mode and Interrupt Register Block

This block holds the control-side state of a CAN controller: a run/enable register, an operating-mode selector, a read-only one-hot status word and a pair of interrupt registers (a flag word and a write-one-to-clear port). Software reaches it over a plain 32-bit register port with a byte address, a write strobe and a combinational read-data return. The protocol engine around it supplies single-cycle strobes for a finished transmit, a finished receive and a frame seen on the bus.

The controller leaves reset disabled, which is the configuration state. Software picks an operating mode while disabled and then sets the enable bit; from then on the mode selector is frozen until the controller is disabled again. A controller that was started in sleep wakes by itself into normal operation as soon as a frame is seen on the bus. Bit timing, serialisation, arbitration, error counting and message buffering live elsewhere.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, the enable register (offset 0x00), mode register (0x04), status word (0x18) and interrupt flags (0x1C) all read 0.
- R2: Writing offset 0x00 stores data bit 1 as the enable bit, read back at bit 1; writing it with bit 1 clear returns the controller to configuration, where status reads 0.
- R3: While enabled, status reads exactly one set bit: 0x0000_0008 for normal, 0x0000_0002 for loopback, 0x0000_0004 for sleep, 0x0000_1000 for snoop.
- R4: The mode register (offset 0x04, bits 2:0) uses 0 for normal, 0x1 for sleep, 0x2 for loopback and 0x4 for snoop; writes to it take effect only while disabled and are ignored (read-back unchanged) while enabled.
- R5: With several mode bits set, sleep wins over loopback and loopback wins over snoop.
- R6: When enabled in sleep, a bus-frame strobe makes status read normal (0x8) and the mode register read 0 from the following cycle.
- R7: While enabled, a transmit-done strobe sets interrupt flag bit 1 (0x02) and a receive-done strobe sets bit 4 (0x10), visible the cycle after the strobe and held until cleared.
- R8: Writing offset 0x24 clears each interrupt flag whose position holds a 1 in the written data, leaves the others, and offset 0x24 reads 0.
- R9: When an event strobe and a clear of the same flag fall in one cycle, the flag ends set.
- R10: While disabled, transmit-done and receive-done strobes leave the interrupt flags unchanged.
- R11: A bus-frame strobe outside sleep leaves the mode and status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe for reg_addr/reg_wdata |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_done_i | input | 1 | One-cycle strobe: a transmit finished |
| rx_done_i | input | 1 | One-cycle strobe: a receive finished |
| bus_frame_i | input | 1 | One-cycle strobe: a frame was seen on the bus |

## Verification
The embedded properties assume the event inputs are true single-cycle strobes that are known after reset, and that the register port issues at most one write per cycle with a stable address. The directed bench drives every strobe for exactly one clock from the falling edge and never holds the write strobe over two edges, so the wake and set-beats-clear properties see the same well-formed pulses a protocol engine would give. Simultaneous event and clear is produced deliberately in one scenario only, to exercise the tie rule.

// File: rtl/can_mode_pkg.sv
// Package: shared constants and types for the CAN mode/interrupt block.
// Assumes byte offsets fit in 8 bits; bit positions are fixed by software.
package can_mode_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned MODE_W = 3;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_RUN    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STATE  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IFLAG  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_ICLR   = 8'h24;

    // bit positions
    localparam int unsigned RUN_BIT        = 1;
    localparam int unsigned MSEL_SLEEP     = 0;
    localparam int unsigned MSEL_LOOP      = 1;
    localparam int unsigned MSEL_SNOOP     = 2;
    localparam int unsigned ST_LOOP_BIT    = 1;
    localparam int unsigned ST_SLEEP_BIT   = 2;
    localparam int unsigned ST_NORMAL_BIT  = 3;
    localparam int unsigned ST_SNOOP_BIT   = 12;
    localparam int unsigned IRQ_TX_BIT     = 1;
    localparam int unsigned IRQ_RX_BIT     = 4;

    typedef enum logic [2:0] {
        OPM_CONFIG,
        OPM_NORMAL,
        OPM_LOOP,
        OPM_SLEEP,
        OPM_SNOOP
    } opmode_t;

    // Resolve the selector into one operating mode; sleep > loop > snoop.
    function automatic opmode_t pick_mode(input logic run, input logic [MODE_W-1:0] sel);
        if (!run)                  return OPM_CONFIG;
        else if (sel[MSEL_SLEEP])  return OPM_SLEEP;
        else if (sel[MSEL_LOOP])   return OPM_LOOP;
        else if (sel[MSEL_SNOOP])  return OPM_SNOOP;
        else                       return OPM_NORMAL;
    endfunction

endpackage

// File: rtl/can_mode_regs.sv
// Module: enable and mode-selector registers with automatic sleep wake-up.
// Assumes wr_run/wr_mode are single-cycle decoded writes and bus_frame is a
// one-cycle strobe. The selector is writable only while the run bit is 0.
module can_mode_regs
    import can_mode_pkg::*;
#(
    parameter int unsigned SEL_W = MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_run,
    input  logic             wr_mode,
    input  logic [DATA_W-1:0] wdata,
    input  logic             bus_frame,
    output logic             run_q,
    output logic [SEL_W-1:0] sel_q
);

    logic wake;

    // A frame seen while running in sleep triggers the return to normal.
    always_comb wake = run_q && sel_q[MSEL_SLEEP] && bus_frame;

    // Run bit: loaded from data bit RUN_BIT on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (wr_run) run_q <= wdata[RUN_BIT];
    end

    // Mode selector: written only in configuration, zeroed on wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sel_q <= '0;
        else if (wake)              sel_q <= '0;
        else if (wr_mode && !run_q) sel_q <= wdata[SEL_W-1:0];
    end

    // R4: selector frozen while running unless a wake-up occurs
    assert_mode_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !(sel_q[MSEL_SLEEP] && bus_frame)) |=> $stable(sel_q));

    // R6: sleep wake-up clears the selector to normal
    assert_sleep_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && sel_q[MSEL_SLEEP] && bus_frame) |=> (sel_q == '0));

    // R11: a bus frame outside sleep leaves the selector alone
    assert_frame_noeffect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_frame && !sel_q[MSEL_SLEEP] && !wr_mode) |=> $stable(sel_q));

endmodule

// File: rtl/can_mode_status.sv
// Module: turns run bit and selector into the one-hot status word.
// Assumes the status word is at least ST_SNOOP_BIT+1 bits wide.
module can_mode_status
    import can_mode_pkg::*;
#(
    parameter int unsigned SEL_W = MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [SEL_W-1:0]  sel,
    output opmode_t           opm,
    output logic [DATA_W-1:0] status
);

    // Priority resolution of the selector.
    always_comb opm = pick_mode(run, sel);

    // One-hot encoding of the resolved mode.
    always_comb begin
        status = '0;
        case (opm)
            OPM_NORMAL: status[ST_NORMAL_BIT] = 1'b1;
            OPM_LOOP:   status[ST_LOOP_BIT]   = 1'b1;
            OPM_SLEEP:  status[ST_SLEEP_BIT]  = 1'b1;
            OPM_SNOOP:  status[ST_SNOOP_BIT]  = 1'b1;
            default:    status = '0;
        endcase
    end

    // R3: exactly one status bit while running, none in configuration
    assert_status_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status) == (run ? 1 : 0));

    // R5: sleep request dominates whatever else is selected
    assert_sleep_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sel[MSEL_SLEEP]) |-> status[ST_SLEEP_BIT]);

endmodule

// File: rtl/can_mode_irq.sv
// Module: sticky interrupt flags, one per event source, write-one-to-clear.
// Assumes events are one-cycle strobes; a set in the same cycle as a clear wins.
module can_mode_irq
    import can_mode_pkg::*;
#(
    parameter int unsigned N_SRC = 2,
    parameter int unsigned POS_W = 5,
    parameter logic [N_SRC*POS_W-1:0] SRC_POS = {5'(IRQ_RX_BIT), 5'(IRQ_TX_BIT)}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [N_SRC-1:0]  ev,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] flags
);

    logic [N_SRC-1:0] flag_q;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            localparam int unsigned POS = SRC_POS[g*POS_W +: POS_W];
            logic set_w;
            logic clr_w;

            // Set only while running; clear from a 1 in the written position.
            always_comb begin
                set_w = run && ev[g];
                clr_w = wr_clr && wdata[POS];
            end

            // Sticky flag: set beats clear.
            always_ff @(posedge clk) begin
                if (!rst_n)     flag_q[g] <= 1'b0;
                else if (set_w) flag_q[g] <= 1'b1;
                else if (clr_w) flag_q[g] <= 1'b0;
            end

            // R7/R9: an accepted event leaves the flag set, even with a clear
            assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (run && ev[g]) |=> flag_q[g]);

            // R8: a clear with no event drops the flag
            assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_clr && wdata[POS] && !(run && ev[g])) |=> !flag_q[g]);

            // R10: no flag can rise while disabled
            assert_idle_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> !$rose(flag_q[g]));
        end
    endgenerate

    // Place flags at their fixed word positions.
    always_comb begin
        flags = '0;
        for (int i = 0; i < N_SRC; i++) flags[SRC_POS[i*POS_W +: POS_W]] = flag_q[i];
    end

endmodule

// File: rtl/can_mode_ctrl.sv
// Module: top of the CAN mode/interrupt register block. Decodes the register
// port, instantiates the mode registers, status encoder and interrupt flags,
// and muxes read data. Assumes one access per cycle, reads are combinational.
module can_mode_ctrl
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_done_i,
    input  logic              rx_done_i,
    input  logic              bus_frame_i
);

    localparam int unsigned N_EV = 2;

    logic              wr_run, wr_mode, wr_clr;
    logic              run_q;
    logic [MODE_W-1:0] sel_q;
    opmode_t           opm;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] flags_w;

    // Write decode.
    always_comb begin
        wr_run  = reg_wr && (reg_addr == OFS_RUN);
        wr_mode = reg_wr && (reg_addr == OFS_MODE);
        wr_clr  = reg_wr && (reg_addr == OFS_ICLR);
    end

    can_mode_regs #(.SEL_W(MODE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_run    (wr_run),
        .wr_mode   (wr_mode),
        .wdata     (reg_wdata),
        .bus_frame (bus_frame_i),
        .run_q     (run_q),
        .sel_q     (sel_q)
    );

    can_mode_status #(.SEL_W(MODE_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .sel    (sel_q),
        .opm    (opm),
        .status (status_w)
    );

    can_mode_irq #(.N_SRC(N_EV)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .ev     ({rx_done_i, tx_done_i}),
        .wr_clr (wr_clr),
        .wdata  (reg_wdata),
        .flags  (flags_w)
    );

    // Read-data multiplexer; the clear port and unmapped offsets read 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_RUN:   reg_rdata[RUN_BIT] = run_q;
            OFS_MODE:  reg_rdata[MODE_W-1:0] = sel_q;
            OFS_STATE: reg_rdata = status_w;
            OFS_IFLAG: reg_rdata = flags_w;
            default:   reg_rdata = '0;
        endcase
    end

    // R2: configuration state tracks the run bit
    assert_config_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_run && !reg_wdata[RUN_BIT]) |=> (opm == OPM_CONFIG));

endmodule

// File: tb/can_mode_ctrl_tb_top.sv
// Directed bench for can_mode_ctrl: one task per scenario.
module can_mode_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        tx_done_i, rx_done_i, bus_frame_i;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_done_i(tx_done_i),
        .rx_done_i(rx_done_i), .bus_frame_i(bus_frame_i)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // all drives happen just after the falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse(input bit tx, input bit rx, input bit fr);
        tx_done_i = tx; rx_done_i = rx; bus_frame_i = fr;
        @(negedge clk);
        tx_done_i = 1'b0; rx_done_i = 1'b0; bus_frame_i = 1'b0;
    endtask

    task automatic start_mode(input logic [31:0] m);
        wr(8'h00, 32'h0);
        wr(8'h04, m);
        wr(8'h00, 32'h2);
    endtask

    task automatic t_reset;
        rd_chk("R1 run",    8'h00, 32'h0);
        rd_chk("R1 mode",   8'h04, 32'h0);
        rd_chk("R1 status", 8'h18, 32'h0);
        rd_chk("R1 flags",  8'h1C, 32'h0);
    endtask

    task automatic t_normal;
        wr(8'h00, 32'h2);
        rd_chk("R2 run readback", 8'h00, 32'h2);
        rd_chk("R3 normal",       8'h18, 32'h8);
    endtask

    task automatic t_events;
        pulse(1, 0, 0);
        rd_chk("R7 tx flag", 8'h1C, 32'h02);
        pulse(0, 1, 0);
        rd_chk("R7 both flags", 8'h1C, 32'h12);
        wr(8'h24, 32'h02);
        rd_chk("R8 clear tx only", 8'h1C, 32'h10);
        rd_chk("R8 clear port reads 0", 8'h24, 32'h0);
        wr(8'h24, 32'h10);
        rd_chk("R8 clear rx", 8'h1C, 32'h0);
    endtask

    task automatic t_set_wins;
        reg_addr = 8'h24; reg_wdata = 32'h12; reg_wr = 1'b1; tx_done_i = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tx_done_i = 1'b0;
        rd_chk("R9 set beats clear", 8'h1C, 32'h02);
        wr(8'h24, 32'h02);
        rd_chk("R8 cleared after tie", 8'h1C, 32'h0);
    endtask

    task automatic t_mode_lock;
        wr(8'h04, 32'h2);
        rd_chk("R4 mode write ignored", 8'h04, 32'h0);
        rd_chk("R4 status unchanged",   8'h18, 32'h8);
    endtask

    task automatic t_disabled;
        wr(8'h00, 32'h0);
        rd_chk("R2 config status", 8'h18, 32'h0);
        rd_chk("R2 run cleared",   8'h00, 32'h0);
        pulse(1, 1, 0);
        rd_chk("R10 events ignored", 8'h1C, 32'h0);
    endtask

    task automatic t_modes;
        start_mode(32'h2);
        rd_chk("R4 loop mode readback", 8'h04, 32'h2);
        rd_chk("R3 loopback",  8'h18, 32'h2);
        pulse(0, 0, 1);
        rd_chk("R11 frame no effect", 8'h18, 32'h2);
        start_mode(32'h4);
        rd_chk("R3 snoop",     8'h18, 32'h1000);
        start_mode(32'h1);
        rd_chk("R3 sleep",     8'h18, 32'h4);
    endtask

    task automatic t_priority;
        start_mode(32'h6);
        rd_chk("R5 loop over snoop", 8'h18, 32'h2);
        start_mode(32'h7);
        rd_chk("R5 sleep over all",  8'h18, 32'h4);
        start_mode(32'h5);
        rd_chk("R5 sleep over snoop", 8'h18, 32'h4);
    endtask

    task automatic t_wake;
        start_mode(32'h1);
        rd_chk("R6 sleeping", 8'h18, 32'h4);
        pulse(0, 0, 1);
        rd_chk("R6 woke to normal", 8'h18, 32'h8);
        rd_chk("R6 mode cleared",   8'h04, 32'h0);
        pulse(0, 1, 0);
        rd_chk("R7 rx after wake", 8'h1C, 32'h10);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        tx_done_i = 1'b0; rx_done_i = 1'b0; bus_frame_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_normal;
        t_events;
        t_set_wins;
        t_mode_lock;
        t_disabled;
        t_modes;
        t_priority;
        t_wake;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule